// File: doc/BRIEF.md
# Clock-Throttling Duty Timer

This block emulates a slower processor clock by switching an active-low stop-clock output back and forth. The output stays high (negated, the processor runs) for a programmed run interval. It then goes low (asserted, the processor is halted) for a programmed halt interval, and the cycle repeats. The run and halt lengths come from two 8-bit settings. One shared down-counter times both intervals and advances only on a slow periodic tick pulse supplied from outside. Each real interval is two ticks longer than its setting, because every countdown has a one-tick load step before it and a one-tick terminal step after it.

A throttle-enable input gates the whole mechanism. While it is low, the output is held negated and the counter is parked. Raising it starts a fresh run interval. A break pulse that arrives during the run phase restarts the run interval, so a system that stays busy never reaches the halted phase. A break pulse that arrives during the halt phase has no effect.

Top module: `thr_duty_timer`

## Requirements
- R1: After synchronous reset, `stop_n` is 1 (negated).
- R2: With enable high and a programmed run value N, `stop_n` stays 1 for exactly N+2 tick pulses. The change to 0 takes effect on the clock edge that samples the last of those ticks.
- R3: With a programmed halt value M, `stop_n` stays 0 for exactly M+2 tick pulses and then returns to 1.
- R4: A programmed value of 0 gives an interval of exactly 2 ticks.
- R5: A programmed value of 255 gives an interval of exactly 257 ticks.
- R6: A break pulse while `stop_n` is 1 restarts the run interval. After the break, `stop_n` stays 1 for exactly N+2 further ticks. A break keeps `stop_n` at 1 on the next edge.
- R7: A break pulse while `stop_n` is 0 does not change the halt interval's length.
- R8: While enable is 0, `stop_n` is 1 from the next clock edge onward, whatever the tick and break inputs do.
- R9: While enable is high, `stop_n` changes only on a clock edge that samples a tick pulse.
- R10: Raising enable starts a run interval: the first fall of `stop_n` comes exactly N+2 ticks later. `stop_n` falls only after a cycle with enable high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Throttle enable |
| run_len | input | CNT_W | Run (negated) interval setting |
| halt_len | input | CNT_W | Halt (asserted) interval setting |
| tick | input | 1 | One-cycle slow time-base pulse |
| brk | input | 1 | One-cycle break-event pulse |
| stop_n | output | 1 | Active-low stop-clock output |

## Verification
The embedded properties check, on every cycle, that disabling forces the output negated, that the output moves only on tick edges while enabled, that a break in the run phase keeps the output high, and that the counter never sits at zero in its counting step. Exact interval lengths, and the fact that a break does not stretch the halt phase, depend on counting ticks across many cycles. Only the bench's sweep over every pair of small settings, the 255 extreme and the break and enable scenarios can show those.

// File: rtl/thr_pkg.sv
package thr_pkg;

    parameter int CNT_W_DEF = 8;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_COUNT = 2'd1,
        ST_TERM  = 2'd2
    } step_e;

    typedef enum logic {
        PH_RUN  = 1'b0,
        PH_HALT = 1'b1
    } phase_e;

    function automatic phase_e other_phase(input phase_e p);
        return (p == PH_RUN) ? PH_HALT : PH_RUN;
    endfunction

endpackage

// File: rtl/thr_len_sel.sv
module thr_len_sel
    import thr_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  phase_e           phase,
    input  logic [CNT_W-1:0] run_len,
    input  logic [CNT_W-1:0] halt_len,
    output logic [CNT_W-1:0] load_val
);
    always_comb begin
        load_val = (phase == PH_RUN) ? run_len : halt_len;
    end
endmodule

// File: rtl/thr_countdown.sv
module thr_countdown
    import thr_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    step_e            step_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            step_q <= ST_LOAD;
            cnt_q  <= ZERO;
        end else if (restart) begin
            step_q <= ST_LOAD;
        end else if (tick) begin
            unique case (step_q)
                ST_LOAD: begin
                    cnt_q  <= load_val;
                    step_q <= (load_val == ZERO) ? ST_TERM : ST_COUNT;
                end
                ST_COUNT: begin
                    cnt_q <= cnt_q - ONE;
                    if (cnt_q == ONE) step_q <= ST_TERM;
                end
                ST_TERM: begin
                    step_q <= ST_LOAD;
                end
                default: step_q <= ST_LOAD;
            endcase
        end
    end

    assign expire = en && tick && !restart && (step_q == ST_TERM);

    p_count_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
        (step_q == ST_COUNT) |-> (cnt_q != ZERO));

    p_restart_reloads_r6: assert property (@(posedge clk) disable iff (rst)
        (en && restart) |=> (step_q == ST_LOAD));
endmodule

// File: rtl/thr_phase.sv
module thr_phase
    import thr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   flip,
    output phase_e phase,
    output logic   stop_n
);
    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst || !en) phase_q <= PH_RUN;
        else if (flip)  phase_q <= other_phase(phase_q);
    end

    assign phase  = phase_q;
    assign stop_n = (phase_q == PH_RUN);

    p_flip_toggles_r3: assert property (@(posedge clk) disable iff (rst)
        (en && flip) |=> (stop_n != $past(stop_n)));
endmodule

// File: rtl/thr_duty_timer.sv
module thr_duty_timer
    import thr_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] run_len,
    input  logic [CNT_W-1:0] halt_len,
    input  logic             tick,
    input  logic             brk,
    output logic             stop_n
);
    phase_e           phase;
    logic [CNT_W-1:0] load_val;
    logic             expire;
    logic             restart;

    // A break only matters while the processor is running.
    assign restart = en && brk && (phase == PH_RUN);

    thr_len_sel #(.CNT_W(CNT_W)) u_sel (
        .phase    (phase),
        .run_len  (run_len),
        .halt_len (halt_len),
        .load_val (load_val)
    );

    thr_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .tick     (tick),
        .restart  (restart),
        .load_val (load_val),
        .expire   (expire)
    );

    thr_phase u_ph (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .flip   (expire),
        .phase  (phase),
        .stop_n (stop_n)
    );

    p_reset_negated_r1: assert property (@(posedge clk)
        rst |=> stop_n);

    p_disable_negates_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> stop_n);

    p_tick_only_r9: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> $stable(stop_n));

    p_break_holds_run_r6: assert property (@(posedge clk) disable iff (rst)
        (en && brk && stop_n) |=> stop_n);

    p_fall_needs_en_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(stop_n) |-> $past(en));
endmodule

// File: tb/test_thr_duty_timer.sv
`timescale 1ns/1ps
module test_thr_duty_timer;
    logic       clk = 1'b0;
    logic       rst;
    logic       en;
    logic [7:0] run_len;
    logic [7:0] halt_len;
    logic       tick;
    logic       brk;
    logic       stop_n;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    thr_duty_timer i_thr_duty_timer (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .run_len  (run_len),
        .halt_len (halt_len),
        .tick     (tick),
        .brk      (brk),
        .stop_n   (stop_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs, then return at the following falling edge.
    task automatic cyc(input logic t, input logic b);
        tick = t;
        brk  = b;
        @(negedge clk);
        tick = 1'b0;
        brk  = 1'b0;
    endtask

    task automatic one_tick();
        cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b0);
    endtask

    // Count ticks until the output toggles; pre = ticks already spent in this phase.
    task automatic meas(input int pre, input int exp, input string tag);
        logic s0;
        int   n;
        int   g;
        s0 = stop_n;
        n  = pre;
        g  = 0;
        while (stop_n == s0 && g < 2000) begin
            cyc(1'b1, 1'b0);
            n++;
            if (stop_n == s0) begin
                cyc(1'b0, 1'b0);
                if (stop_n != s0) check(1'b0, "R9 toggle without tick", 1, 0);
            end
            g++;
        end
        check(n == exp, tag, n, exp);
    endtask

    task automatic start(input logic [7:0] r, input logic [7:0] h);
        en = 1'b0;
        cyc(1'b0, 1'b0);
        run_len  = r;
        halt_len = h;
        en = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; en = 1'b0; run_len = '0; halt_len = '0; tick = 1'b0; brk = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(stop_n == 1'b1, "R1 reset state", int'(stop_n), 1);

        // R2 / R3 / R4 / R10: every pair of small settings
        for (int r = 0; r < 8; r++) begin
            for (int h = 0; h < 8; h++) begin
                start(8'(r), 8'(h));
                meas(0, r + 2, (r == 0) ? "R4 R10 run zero" : "R10 R2 first run");
                meas(0, h + 2, (h == 0) ? "R4 halt zero" : "R3 halt");
                meas(0, r + 2, "R2 run repeat");
            end
        end

        // R5: largest setting
        start(8'd255, 8'd255);
        meas(0, 257, "R5 run max");
        meas(0, 257, "R5 halt max");

        // R6: break in the run phase restarts it
        start(8'd6, 8'd2);
        for (int k = 0; k < 4; k++) one_tick();
        cyc(1'b0, 1'b1);
        check(stop_n == 1'b1, "R6 break keeps run", int'(stop_n), 1);
        meas(0, 8, "R6 run after break");

        // R7: break in the halt phase is ignored
        one_tick();
        one_tick();
        cyc(1'b0, 1'b1);
        check(stop_n == 1'b0, "R7 break in halt", int'(stop_n), 0);
        meas(2, 4, "R7 halt length");

        // R8: disable during halt
        start(8'd3, 8'd4);
        meas(0, 5, "R10 run before disable");
        check(stop_n == 1'b0, "R8 in halt", int'(stop_n), 0);
        one_tick();
        en = 1'b0;
        cyc(1'b0, 1'b0);
        check(stop_n == 1'b1, "R8 disable negates", int'(stop_n), 1);
        begin
            int lows;
            lows = 0;
            for (int k = 0; k < 20; k++) begin
                cyc(1'b1, k[0]);
                if (stop_n != 1'b1) lows++;
            end
            check(lows == 0, "R8 held while disabled", lows, 0);
        end
        en = 1'b1;
        meas(0, 5, "R10 run after re-enable");
        meas(0, 6, "R3 halt after re-enable");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule